// File: doc/BRIEF.md
# Command-Byte Register Controller

This block sits behind a serial slave front end that has already decoded the bus into events. It sees a start-of-transfer pulse, one pulse for each byte written by the host, and one pulse for each byte the host reads. The first byte written in a transfer selects a command. Every later written byte is a parameter for that command. Reads return the selected command's result one byte per request, starting with the least significant byte. A cycle counter, cleared at every transfer start, gives the byte position.

The controller holds the settings registers: configuration, active time, debounce time, keypad size, clock setup, and three 16-bit GPIO words (pull, direction, output state). It also holds an interrupt status register and a sticky error register. It checks each parameter as it arrives. A bad value, an unknown command or a surplus byte sets an error bit and raises the active-low interrupt. Key events arrive from an external key FIFO. The controller reaches that FIFO through a peek index, a pop strobe and a flush strobe.

Top module: `cmdif_ctrl`

## Requirements
- R1: A transfer start clears the byte counter. In a write transfer, byte 0 is taken as the command code and byte n (n ≥ 1) as parameter n−1. Each read request returns byte k of the result, where k is the counter value, and then advances the counter.
- R2: After reset the registers hold: configuration 0x80, status 0x10 (only the not-initialised bit, bit 4), active time 125, debounce 3, keypad size 0x33, clock 0x08, all GPIO words 0 and error 0.
- R3: `irq_n` is low whenever the status register is nonzero, so any error drives it low on the following cycle.
- R4: Error bits are sticky. Bad parameter is bit 0, unknown command is bit 1, key overrun is bit 2 and FIFO overflow is bit 6. Each error also sets status bit 3. No command clears them; only `rst_n` does.
- R5: When a command has taken all of its parameters, the latched command becomes 0xFF. Any further parameter byte then sets bad-parameter.
- R6: Command 0x83 with parameter 0xAA restores every value listed in R2 except the error and GPIO registers. Any other parameter sets bad-parameter and changes nothing else.
- R7: Command 0x81 stores its parameter as the configuration, clears the status and flushes the key FIFO. Command 0x92 returns only configuration bits 3:0.
- R8: Command 0x90 always stores its parameter as the keypad size. It sets bad-parameter unless bits 3:0 are in 3..12 and bits 7:4 are in 3..8.
- R9: Command 0x8F stores the debounce value and flags bad-parameter when the value is 0. Command 0x93 stores the clock byte and flags bad-parameter when bits 1:0 are 01 or 10. Command 0x94 returns the clock byte with bits 1:0 replaced by 10.
- R10: Commands 0x84, 0x85 and 0x86 write the pull, direction and state words. The first parameter replaces the whole word with a zero-extended byte. The second parameter is ORed into bits 15:8. Commands 0x87 and 0x88 return direction and state, low byte first, then 0.
- R11: Command 0x80 returns 0x00, then 0x04, then 0 for any later byte.
- R12: Command 0x82 returns the status on byte 0 and 0 on later bytes. Each read clears the status unless bit 4 is set. A key event sets status bit 0. A FIFO overflow pulse sets error bit 6.
- R13: Writing a parameter to an unrecognised command, or reading one, sets unknown-command and returns 0. Command 0x8E reads 0 without error.
- R14: Command 0x89 returns the FIFO head and pops it, or returns 0 when the FIFO is empty. Command 0x8A returns entry k of the FIFO without popping, or 0 when k is not below the FIFO count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start of a transfer (either direction) |
| wr_valid | input | 1 | One byte written by the host |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Host consumes one read byte |
| rd_data | output | 8 | Byte presented for the current read position |
| key_event | input | 1 | A key code was pushed into the key FIFO |
| fifo_ovf | input | 1 | The key FIFO dropped an event |
| fifo_count | input | CNT_W (5) | Entries in the key FIFO |
| fifo_peek_data | input | 8 | Entry at `fifo_peek_idx` from the head |
| fifo_peek_idx | output | IDX_W (4) | Offset from the FIFO head to look at |
| fifo_pop | output | 1 | Remove the FIFO head |
| fifo_flush | output | 1 | Empty the FIFO |
| irq_n | output | 1 | Active-low interrupt |
| cfg_o | output | 8 | Configuration byte |
| act_time_o | output | 8 | Active time |
| debounce_o | output | 8 | Debounce time |
| kp_size_o | output | 8 | Keypad size (columns in bits 7:4, rows in bits 3:0) |
| clk_cfg_o | output | 8 | Clock setup byte |
| gpio_pull_o | output | 16 | GPIO pull selection |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_state_o | output | 16 | GPIO output state |

## Verification
Some behaviours are checked by the assertions on every cycle. Any error lowers the interrupt on the next cycle. Error bits never fall. A parameter byte sent to a finished command always leaves bad-parameter set. A status read never drops the not-initialised bit. The FIFO is never popped while empty. The value rules can only be shown by the bench's directed scenarios, because each depends on a specific byte sequence. Those rules are the keypad-size range limits, the clock and debounce checks, the low-byte-first GPIO merge, the magic reset parameter, the read-out masking and the FIFO peek and pop contents.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam int GPIO_W = 16;
    localparam int N_GPIO = 3;

    // command codes
    localparam logic [7:0] OP_ID        = 8'h80;
    localparam logic [7:0] OP_CFG_W     = 8'h81;
    localparam logic [7:0] OP_STAT_R    = 8'h82;
    localparam logic [7:0] OP_RESET     = 8'h83;
    localparam logic [7:0] OP_PULL_W    = 8'h84; // pull, dir, state are consecutive
    localparam logic [7:0] OP_DIR_R     = 8'h87;
    localparam logic [7:0] OP_STATE_R   = 8'h88;
    localparam logic [7:0] OP_FIFO_POP  = 8'h89;
    localparam logic [7:0] OP_FIFO_PEEK = 8'h8A;
    localparam logic [7:0] OP_ACT_W     = 8'h8B;
    localparam logic [7:0] OP_ERR_R     = 8'h8C;
    localparam logic [7:0] OP_ROT_R     = 8'h8E;
    localparam logic [7:0] OP_DBN_W     = 8'h8F;
    localparam logic [7:0] OP_SIZE_W    = 8'h90;
    localparam logic [7:0] OP_SIZE_R    = 8'h91;
    localparam logic [7:0] OP_CFG_R     = 8'h92;
    localparam logic [7:0] OP_CLK_W     = 8'h93;
    localparam logic [7:0] OP_CLK_R     = 8'h94;
    localparam logic [7:0] OP_IDLE      = 8'hFF;

    localparam logic [7:0] RESET_MAGIC  = 8'hAA;
    localparam logic [15:0] CHIP_ID     = 16'h0400;

    // status bit positions (bits 7:5 are reserved for waveform-end flags)
    localparam int ST_KEY    = 0;
    localparam int ST_ERR    = 3;
    localparam int ST_NOINIT = 4;

    // error bit positions
    localparam int ER_BADPAR  = 0;
    localparam int ER_UNK     = 1;
    localparam int ER_KEYOVR  = 2;
    localparam int ER_FIFOOVR = 6;

    // reset values
    localparam logic [7:0] RV_CFG    = 8'h80;
    localparam logic [7:0] RV_STATUS = 8'h10;
    localparam logic [7:0] RV_ACT    = 8'd125;
    localparam logic [7:0] RV_DBN    = 8'd3;
    localparam logic [7:0] RV_SIZE   = 8'h33;
    localparam logic [7:0] RV_CLK    = 8'h08;

    // decoded effect of one parameter byte
    typedef struct packed {
        logic              ld_cfg;
        logic              ld_act;
        logic              ld_dbn;
        logic              ld_size;
        logic              ld_clk;
        logic [N_GPIO-1:0] gp_lo;
        logic [N_GPIO-1:0] gp_hi;
        logic              soft_rst;
        logic              done;
        logic [7:0]        err_set;
    } wr_act_t;

endpackage

// File: rtl/cmdif_wr_dec.sv
module cmdif_wr_dec
    import cmdif_pkg::*;
#(
    parameter int CYC_W    = 4,
    parameter int MIN_DIM  = 3,
    parameter int MAX_ROWS = 12,
    parameter int MAX_COLS = 8
) (
    input  logic [7:0]       cmd,
    input  logic [CYC_W-1:0] pidx,
    input  logic [7:0]       data,
    output wr_act_t          act
);
    localparam logic [3:0] L_MIN  = 4'(MIN_DIM);
    localparam logic [3:0] L_ROWS = 4'(MAX_ROWS);
    localparam logic [3:0] L_COLS = 4'(MAX_COLS);

    logic [3:0] rows;
    logic [3:0] cols;
    logic       size_bad;
    logic       is_gpio;

    assign rows     = data[3:0];
    assign cols     = data[7:4];
    assign size_bad = (rows < L_MIN) || (rows > L_ROWS) ||
                      (cols < L_MIN) || (cols > L_COLS);

    always_comb begin
        act     = '0;
        is_gpio = 1'b0;
        for (int k = 0; k < N_GPIO; k++) begin
            if (cmd == OP_PULL_W + 8'(k)) begin
                is_gpio = 1'b1;
                if (pidx == '0) begin
                    act.gp_lo[k] = 1'b1;
                end else begin
                    act.gp_hi[k] = 1'b1;
                    act.done     = 1'b1;
                end
            end
        end
        if (!is_gpio) begin
            case (cmd)
                OP_CFG_W: begin
                    act.ld_cfg = 1'b1;
                    act.done   = 1'b1;
                end
                OP_RESET: begin
                    act.done = 1'b1;
                    if (data == RESET_MAGIC) act.soft_rst = 1'b1;
                    else                     act.err_set[ER_BADPAR] = 1'b1;
                end
                OP_ACT_W: begin
                    act.ld_act = 1'b1;
                    act.done   = 1'b1;
                end
                OP_DBN_W: begin
                    act.ld_dbn = 1'b1;
                    act.done   = 1'b1;
                    act.err_set[ER_BADPAR] = (data == 8'h00);
                end
                OP_SIZE_W: begin
                    act.ld_size = 1'b1;
                    act.done    = 1'b1;
                    act.err_set[ER_BADPAR] = size_bad;
                end
                OP_CLK_W: begin
                    act.ld_clk = 1'b1;
                    act.done   = 1'b1;
                    act.err_set[ER_BADPAR] = data[1] ^ data[0];
                end
                OP_IDLE: act.err_set[ER_BADPAR] = 1'b1;
                default: act.err_set[ER_UNK] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cmdif_rd_sel.sv
module cmdif_rd_sel
    import cmdif_pkg::*;
#(
    parameter int CYC_W = 4,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic [7:0]        cmd,
    input  logic [CYC_W-1:0]  bidx,
    input  logic [7:0]        status,
    input  logic [7:0]        err,
    input  logic [7:0]        size,
    input  logic [3:0]        cfg_lo,
    input  logic [7:2]        clk_hi,
    input  logic [GPIO_W-1:0] gp_dir,
    input  logic [GPIO_W-1:0] gp_state,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [7:0]        fifo_peek_data,
    output logic [IDX_W-1:0]  peek_idx,
    output logic [7:0]        rd_byte,
    output logic              clr_status,
    output logic              pop,
    output logic [7:0]        err_set
);
    function automatic logic [7:0] pick16(input logic [15:0] v, input logic [CYC_W-1:0] i);
        if (i == '0)                  return v[7:0];
        else if (i == CYC_W'(1))      return v[15:8];
        else                          return 8'h00;
    endfunction

    always_comb begin
        rd_byte    = 8'h00;
        clr_status = 1'b0;
        pop        = 1'b0;
        err_set    = '0;
        peek_idx   = '0;
        case (cmd)
            OP_ID:      rd_byte = pick16(CHIP_ID, bidx);
            OP_STAT_R: begin
                rd_byte    = (bidx == '0) ? status : 8'h00;
                clr_status = !status[ST_NOINIT];
            end
            OP_DIR_R:   rd_byte = pick16(gp_dir, bidx);
            OP_STATE_R: rd_byte = pick16(gp_state, bidx);
            OP_FIFO_POP: begin
                if (fifo_count != '0) begin
                    rd_byte = fifo_peek_data;
                    pop     = 1'b1;
                end
            end
            OP_FIFO_PEEK: begin
                peek_idx = IDX_W'(bidx);
                if (int'(bidx) < int'(fifo_count)) rd_byte = fifo_peek_data;
            end
            OP_ERR_R:   rd_byte = err;
            OP_ROT_R:   rd_byte = 8'h00;
            OP_SIZE_R:  rd_byte = size;
            OP_CFG_R:   rd_byte = {4'h0, cfg_lo};
            OP_CLK_R:   rd_byte = {clk_hi, 2'b10};
            default:    err_set[ER_UNK] = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmdif_ctrl.sv
module cmdif_ctrl
    import cmdif_pkg::*;
#(
    parameter int CYC_W      = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int MIN_DIM    = 3,
    parameter int MAX_ROWS   = 12,
    parameter int MAX_COLS   = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int IDX_W     = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    input  logic              key_event,
    input  logic              fifo_ovf,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [7:0]        fifo_peek_data,
    output logic [IDX_W-1:0]  fifo_peek_idx,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output logic              irq_n,
    output logic [7:0]        cfg_o,
    output logic [7:0]        act_time_o,
    output logic [7:0]        debounce_o,
    output logic [7:0]        kp_size_o,
    output logic [7:0]        clk_cfg_o,
    output logic [15:0]       gpio_pull_o,
    output logic [15:0]       gpio_dir_o,
    output logic [15:0]       gpio_state_o
);
    localparam logic [CYC_W-1:0] CYC_MAX = '1;

    typedef struct packed {
        logic [7:0]                    cmd;
        logic [CYC_W-1:0]              cyc;
        logic [7:0]                    cfg;
        logic [7:0]                    status;
        logic [7:0]                    err;
        logic [7:0]                    act;
        logic [7:0]                    dbn;
        logic [7:0]                    size;
        logic [7:0]                    clk;
        logic [N_GPIO-1:0][GPIO_W-1:0] gpio;
    } state_t;

    localparam state_t RST_STATE = '{
        cmd: OP_IDLE, cyc: '0, cfg: RV_CFG, status: RV_STATUS, err: '0,
        act: RV_ACT, dbn: RV_DBN, size: RV_SIZE, clk: RV_CLK, gpio: '0
    };

    state_t     q, d;
    wr_act_t    wa;
    logic [7:0] rs_err;
    logic [7:0] err_set;
    logic       rs_clr;
    logic       rs_pop;

    cmdif_wr_dec #(
        .CYC_W(CYC_W), .MIN_DIM(MIN_DIM), .MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)
    ) u_wr (
        .cmd  (q.cmd),
        .pidx (q.cyc - CYC_W'(1)),
        .data (wr_data),
        .act  (wa)
    );

    cmdif_rd_sel #(
        .CYC_W(CYC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_rd (
        .cmd            (q.cmd),
        .bidx           (q.cyc),
        .status         (q.status),
        .err            (q.err),
        .size           (q.size),
        .cfg_lo         (q.cfg[3:0]),
        .clk_hi         (q.clk[7:2]),
        .gp_dir         (q.gpio[1]),
        .gp_state       (q.gpio[2]),
        .fifo_count     (fifo_count),
        .fifo_peek_data (fifo_peek_data),
        .peek_idx       (fifo_peek_idx),
        .rd_byte        (rd_data),
        .clr_status     (rs_clr),
        .pop            (rs_pop),
        .err_set        (rs_err)
    );

    always_comb begin
        d          = q;
        err_set    = '0;
        fifo_pop   = 1'b0;
        fifo_flush = 1'b0;
        if (xfer_start) begin
            d.cyc = '0;
        end else if (wr_valid) begin
            if (q.cyc == '0) begin
                d.cmd = wr_data;
            end else begin
                if (wa.ld_cfg) begin
                    d.cfg      = wr_data;
                    d.status   = '0;
                    fifo_flush = 1'b1;
                end
                if (wa.ld_act)  d.act  = wr_data;
                if (wa.ld_dbn)  d.dbn  = wr_data;
                if (wa.ld_size) d.size = wr_data;
                if (wa.ld_clk)  d.clk  = wr_data;
                for (int k = 0; k < N_GPIO; k++) begin
                    if (wa.gp_lo[k]) d.gpio[k] = {8'h00, wr_data};
                    if (wa.gp_hi[k]) d.gpio[k] = q.gpio[k] | {wr_data, 8'h00};
                end
                if (wa.soft_rst) begin
                    d.cfg    = RV_CFG;
                    d.status = RV_STATUS;
                    d.act    = RV_ACT;
                    d.dbn    = RV_DBN;
                    d.size   = RV_SIZE;
                    d.clk    = RV_CLK;
                end
                if (wa.done) d.cmd = OP_IDLE;
                err_set = wa.err_set;
            end
            if (q.cyc != CYC_MAX) d.cyc = q.cyc + CYC_W'(1);
        end else if (rd_req) begin
            if (rs_clr) d.status = '0;
            fifo_pop = rs_pop;
            err_set  = rs_err;
            if (q.cyc != CYC_MAX) d.cyc = q.cyc + CYC_W'(1);
        end
        if (key_event) d.status[ST_KEY] = 1'b1;
        if (fifo_ovf)  err_set[ER_FIFOOVR] = 1'b1;
        if (err_set != '0) begin
            d.err            = d.err | err_set;
            d.status[ST_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_STATE;
        else        q <= d;
    end

    assign irq_n        = (q.status == 8'h00);
    assign cfg_o        = q.cfg;
    assign act_time_o   = q.act;
    assign debounce_o   = q.dbn;
    assign kp_size_o    = q.size;
    assign clk_cfg_o    = q.clk;
    assign gpio_pull_o  = q.gpio[0];
    assign gpio_dir_o   = q.gpio[1];
    assign gpio_state_o = q.gpio[2];

    // R3: a raised error shows on the interrupt pin one cycle later
    p_err_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != 8'h00) |=> !irq_n);

    // R4: no error bit ever falls while out of reset
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((q.err & $past(q.err)) == $past(q.err)));

    // R5: a byte sent to a finished command leaves bad-parameter set
    p_done_param_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !xfer_start && q.cyc != '0 && q.cmd == OP_IDLE) |=> q.err[ER_BADPAR]);

    // R12: a status read never drops the not-initialised flag
    p_noinit_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_valid && !xfer_start && q.cmd == OP_STAT_R && q.status[ST_NOINIT])
        |=> q.status[ST_NOINIT]);

    // R14: the FIFO is never popped while empty
    p_pop_nonempty_r14: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_count != '0));

endmodule

// File: tb/sim_cmdif_ctrl.sv
module sim_cmdif_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_data;
    logic        key_event = 1'b0;
    logic        fifo_ovf = 1'b0;
    logic [4:0]  fifo_count;
    logic [7:0]  fifo_peek_data;
    logic [3:0]  fifo_peek_idx;
    logic        fifo_pop, fifo_flush, irq_n;
    logic [7:0]  cfg_o, act_time_o, debounce_o, kp_size_o, clk_cfg_o;
    logic [15:0] gpio_pull_o, gpio_dir_o, gpio_state_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // external key FIFO model
    logic [7:0] fmem [16];
    logic [3:0] fhead;
    logic       push_req = 1'b0;
    logic [7:0] push_code = 8'h00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fhead      <= '0;
            fifo_count <= '0;
        end else if (fifo_flush) begin
            fifo_count <= '0;
        end else if (push_req) begin
            fmem[fhead + fifo_count[3:0]] <= push_code;
            fifo_count <= fifo_count + 5'd1;
        end else if (fifo_pop) begin
            fhead      <= fhead + 4'd1;
            fifo_count <= fifo_count - 5'd1;
        end
    end
    assign fifo_peek_data = fmem[fhead + fifo_peek_idx];

    cmdif_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .key_event(key_event),
        .fifo_ovf(fifo_ovf), .fifo_count(fifo_count), .fifo_peek_data(fifo_peek_data),
        .fifo_peek_idx(fifo_peek_idx), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
        .irq_n(irq_n), .cfg_o(cfg_o), .act_time_o(act_time_o), .debounce_o(debounce_o),
        .kp_size_o(kp_size_o), .clk_cfg_o(clk_cfg_o), .gpio_pull_o(gpio_pull_o),
        .gpio_dir_o(gpio_dir_o), .gpio_state_o(gpio_state_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_x();
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        wr_data  = b;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        v      = rd_data;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic read_cmd(input logic [7:0] c, output logic [7:0] v);
        start_x();
        send(c);
        start_x();
        rd(v);
    endtask

    task automatic wr1(input logic [7:0] c, input logic [7:0] p);
        start_x();
        send(c);
        send(p);
    endtask

    task automatic push_key(input logic [7:0] code);
        push_code = code;
        push_req  = 1'b1;
        key_event = 1'b1;
        @(negedge clk);
        push_req  = 1'b0;
        key_event = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hw_reset();
        chk("R2 irq_n", 16'(irq_n), 16'h0);
        chk("R2 cfg", 16'(cfg_o), 16'h80);
        chk("R2 act", 16'(act_time_o), 16'd125);
        chk("R2 dbn", 16'(debounce_o), 16'd3);
        chk("R2 size", 16'(kp_size_o), 16'h33);
        chk("R2 clk", 16'(clk_cfg_o), 16'h08);
        chk("R2 gpio", gpio_pull_o | gpio_dir_o | gpio_state_o, 16'h0);
        read_cmd(8'h82, v); chk("R2 status", 16'(v), 16'h10);
        read_cmd(8'h82, v); chk("R12 noinit kept", 16'(v), 16'h10);
        read_cmd(8'h8C, v); chk("R2 error", 16'(v), 16'h00);
        read_cmd(8'h92, v); chk("R7 cfg low nibble", 16'(v), 16'h00);
        read_cmd(8'h94, v); chk("R9 clk read", 16'(v), 16'h0A);
        read_cmd(8'h91, v); chk("R8 size read", 16'(v), 16'h33);
    endtask

    task automatic t_chip_id();
        logic [7:0] v;
        hw_reset();
        start_x(); send(8'h80); start_x();
        rd(v); chk("R11 id byte0", 16'(v), 16'h00);
        rd(v); chk("R11 id byte1", 16'(v), 16'h04);
        rd(v); chk("R11 id byte2", 16'(v), 16'h00);
        start_x();
        rd(v); chk("R1 counter cleared", 16'(v), 16'h00);
        rd(v); chk("R1 counter steps", 16'(v), 16'h04);
    endtask

    task automatic t_config();
        logic [7:0] v;
        hw_reset();
        push_key(8'h11);
        push_key(8'h22);
        wr1(8'h81, 8'h5C);
        chk("R7 flush", 16'(fifo_count), 16'h0);
        chk("R7 status cleared irq", 16'(irq_n), 16'h1);
        chk("R7 cfg stored", 16'(cfg_o), 16'h5C);
        read_cmd(8'h92, v); chk("R7 cfg read", 16'(v), 16'h0C);
        start_x(); send(8'h81); send(8'h5C); send(8'h11);
        chk("R5 cfg kept", 16'(cfg_o), 16'h5C);
        chk("R3 irq on error", 16'(irq_n), 16'h0);
        read_cmd(8'h8C, v); chk("R5 surplus byte", 16'(v), 16'h01);
        read_cmd(8'h82, v); chk("R4 status err bit", 16'(v), 16'h08);
        read_cmd(8'h82, v); chk("R12 read clears", 16'(v), 16'h00);
        chk("R3 irq released", 16'(irq_n), 16'h1);
        read_cmd(8'h8C, v); chk("R4 sticky", 16'(v), 16'h01);
    endtask

    task automatic t_gpio();
        logic [7:0] v;
        hw_reset();
        start_x(); send(8'h85); send(8'h34); send(8'h12);
        chk("R10 dir", gpio_dir_o, 16'h1234);
        start_x(); send(8'h87); start_x();
        rd(v); chk("R10 dir lo", 16'(v), 16'h34);
        rd(v); chk("R10 dir hi", 16'(v), 16'h12);
        rd(v); chk("R10 dir beyond", 16'(v), 16'h00);
        start_x(); send(8'h85); send(8'h56);
        chk("R10 first byte replaces", gpio_dir_o, 16'h0056);
        start_x(); send(8'h85); send(8'h00); send(8'h80);
        chk("R10 second byte ors", gpio_dir_o, 16'h8000);
        start_x(); send(8'h84); send(8'h0F); send(8'hF0);
        chk("R10 pull", gpio_pull_o, 16'hF00F);
        start_x(); send(8'h86); send(8'hAA); send(8'h55);
        chk("R10 state", gpio_state_o, 16'h55AA);
        start_x(); send(8'h88); start_x();
        rd(v); chk("R10 state lo", 16'(v), 16'hAA);
        rd(v); chk("R10 state hi", 16'(v), 16'h55);
        read_cmd(8'h8C, v); chk("R10 no error", 16'(v), 16'h00);
    endtask

    task automatic size_case(input logic [7:0] p, input logic [7:0] exp_err);
        logic [7:0] v;
        hw_reset();
        wr1(8'h90, p);
        chk("R8 size stored", 16'(kp_size_o), 16'(p));
        read_cmd(8'h8C, v);
        chk("R8 size check", 16'(v), 16'(exp_err));
    endtask

    task automatic t_size();
        size_case(8'h38, 8'h00);
        size_case(8'h2C, 8'h01);
        size_case(8'h3D, 8'h01);
        size_case(8'h93, 8'h01);
        size_case(8'h8C, 8'h00);
        size_case(8'h33, 8'h00);
        size_case(8'h32, 8'h01);
    endtask

    task automatic t_dbn_clk();
        logic [7:0] v;
        hw_reset(); wr1(8'h8F, 8'h00);
        chk("R9 dbn stored", 16'(debounce_o), 16'h00);
        read_cmd(8'h8C, v); chk("R9 dbn zero bad", 16'(v), 16'h01);
        hw_reset(); wr1(8'h8F, 8'h05);
        chk("R9 dbn 5", 16'(debounce_o), 16'h05);
        read_cmd(8'h8C, v); chk("R9 dbn ok", 16'(v), 16'h00);
        hw_reset(); wr1(8'h93, 8'h01);
        read_cmd(8'h8C, v); chk("R9 clk 01 bad", 16'(v), 16'h01);
        hw_reset(); wr1(8'h93, 8'h02);
        read_cmd(8'h8C, v); chk("R9 clk 10 bad", 16'(v), 16'h01);
        hw_reset(); wr1(8'h93, 8'h57);
        chk("R9 clk stored", 16'(clk_cfg_o), 16'h57);
        read_cmd(8'h8C, v); chk("R9 clk 11 ok", 16'(v), 16'h00);
        read_cmd(8'h94, v); chk("R9 clk read forced", 16'(v), 16'h56);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        hw_reset();
        wr1(8'h81, 8'h03);
        wr1(8'h8B, 8'h20);
        start_x(); send(8'h85); send(8'h12); send(8'h34);
        wr1(8'h83, 8'h55);
        chk("R6 bad magic keeps act", 16'(act_time_o), 16'h20);
        read_cmd(8'h8C, v); chk("R6 bad magic error", 16'(v), 16'h01);
        wr1(8'h83, 8'hAA);
        chk("R6 cfg restored", 16'(cfg_o), 16'h80);
        chk("R6 act restored", 16'(act_time_o), 16'd125);
        chk("R6 gpio kept", gpio_dir_o, 16'h3412);
        read_cmd(8'h82, v); chk("R6 status noinit", 16'(v), 16'h10);
        read_cmd(8'h8C, v); chk("R4 error survives", 16'(v), 16'h01);
    endtask

    task automatic t_unknown();
        logic [7:0] v;
        hw_reset();
        start_x(); send(8'h77); send(8'h01);
        read_cmd(8'h8C, v); chk("R13 unknown write", 16'(v), 16'h02);
        hw_reset();
        read_cmd(8'h8D, v); chk("R13 unknown read data", 16'(v), 16'h00);
        read_cmd(8'h8C, v); chk("R13 unknown read err", 16'(v), 16'h02);
        hw_reset();
        read_cmd(8'h8E, v); chk("R13 rotator zero", 16'(v), 16'h00);
        read_cmd(8'h8C, v); chk("R13 rotator no err", 16'(v), 16'h00);
        hw_reset();
        wr1(8'h95, 8'h01);
        read_cmd(8'h8C, v); chk("R13 pwm unknown", 16'(v), 16'h02);
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        hw_reset();
        wr1(8'h81, 8'h00);
        push_key(8'hBC);
        push_key(8'h3C);
        chk("R12 key irq", 16'(irq_n), 16'h0);
        start_x(); send(8'h8A); start_x();
        rd(v); chk("R14 peek 0", 16'(v), 16'hBC);
        rd(v); chk("R14 peek 1", 16'(v), 16'h3C);
        rd(v); chk("R14 peek beyond", 16'(v), 16'h00);
        chk("R14 peek no pop", 16'(fifo_count), 16'd2);
        start_x(); send(8'h89); start_x();
        rd(v); chk("R14 pop 0", 16'(v), 16'hBC);
        rd(v); chk("R14 pop 1", 16'(v), 16'h3C);
        rd(v); chk("R14 pop empty", 16'(v), 16'h00);
        chk("R14 drained", 16'(fifo_count), 16'd0);
        read_cmd(8'h82, v); chk("R12 key status", 16'(v), 16'h01);
        read_cmd(8'h82, v); chk("R12 key cleared", 16'(v), 16'h00);
        fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
        read_cmd(8'h8C, v); chk("R12 overflow err", 16'(v), 16'h40);
        read_cmd(8'h82, v); chk("R12 overflow status", 16'(v), 16'h08);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_chip_id();
        t_config();
        t_gpio();
        t_size();
        t_dbn_clk();
        t_soft_reset();
        t_unknown();
        t_fifo();
        summary();
    end
endmodule